// File: doc/BRIEF.md
# Pixel-Triplet Parity Embedder

This block hides three secret bits in a group of three grey-level cover pixels. Each pixel is first pulled in from the extreme levels. The block then computes a cyclic parity of the group and compares it against the message bits. It alters at most one pixel by a single grey level, so that the parity of the stego group equals the message. Which pixel changes, and in which direction, is chosen with multiplexers driven by the pixel LSB. No divider or multiplier is used.

When all three parity terms disagree with the message, the group is passed through with its pixels unaltered. It is flagged as deferred, and a later decision stage picks the change. For every pixel the block alters, it emits a record of the old and new grey level, so that outside counter logic can keep a histogram-compensation tally. A valid/ready handshake carries one group per transfer, through a single registered output stage.

Top module: `pixel_triplet_embed`

## Requirements
- R1: The parity term for an ordered pair (a, b) is bit 0 of a + (b >> 1). For every output that is not deferred, the terms (y0,y1), (y1,y2) and (y2,y0) equal in_msg bits 0, 1 and 2 respectively.
- R2: Before any other step, an input pixel of 0 becomes 1 and an input pixel of 255 becomes 254. This holds for every output pixel, changed or not.
- R3: When the mismatch vector (in_msg XOR parity terms of the saturated inputs) is 000, the outputs equal the saturated inputs, out_defer is 0 and chg_valid is 0.
- R4: When the mismatch vector has exactly one bit set at position k, pixel k gets a minor step: +1 if it is even, -1 if it is odd.
- R5: When the mismatch vector has two bits set, pixel k gets a major step (-1 if even, +1 if odd). Here k is the bit whose cyclic lower neighbour (k-1 mod 3) is also set: 011 selects pixel 1, 110 selects pixel 2, 101 selects pixel 0.
- R6: When the mismatch vector is 111, out_defer is 1, the outputs equal the saturated inputs, and chg_valid is 0.
- R7: When a pixel is altered, chg_valid is 1 together with out_valid. chg_idx gives the pixel index (0..2), chg_old its saturated level and chg_new its output level, and the two differ by exactly 1.
- R8: in_ready is high when the output register is empty or being drained. A group accepted on a clock edge appears with out_valid high right after that edge. While out_valid is high and out_ready is low, all outputs hold.
- R9: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input group present |
| in_ready | output | 1 | Block can take a group |
| in_pix0 | input | 8 | Cover pixel 0 |
| in_pix1 | input | 8 | Cover pixel 1 |
| in_pix2 | input | 8 | Cover pixel 2 |
| in_msg | input | 3 | Secret bits, bit k for term k |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_pix0 | output | 8 | Stego pixel 0 |
| out_pix1 | output | 8 | Stego pixel 1 |
| out_pix2 | output | 8 | Stego pixel 2 |
| out_defer | output | 1 | Group left for the random-decision stage |
| chg_valid | output | 1 | Transition record valid |
| chg_idx | output | 2 | Index of altered pixel |
| chg_old | output | 8 | Level before the step |
| chg_new | output | 8 | Level after the step |

## Verification
Every result is due exactly one clock edge after its group is accepted. It then stays on the output for as many edges as out_ready is held low. The bench samples mid-cycle at the falling edge. The driver checks that out_valid is high right after each acceptance edge. The scoreboard pops an expected item only at a falling edge where out_valid and out_ready are both high, because that result leaves at the next rising edge. During stalls, each falling edge compares all outputs against the values held at the previous one.

// File: rtl/pte_pkg.sv
package pte_pkg;
   typedef enum logic [1:0] {
      STEP_NONE  = 2'd0,
      STEP_MINOR = 2'd1,
      STEP_MAJOR = 2'd2
   } step_e;

   localparam int unsigned LANES = 3;
endpackage

// File: rtl/pte_parity.sv
module pte_parity #(
   parameter int unsigned PIX_W = 8
) (
   input  logic [2:0][PIX_W-1:0] pix,
   input  logic [2:0]            msg,
   output logic [2:0]            term,
   output logic [2:0]            mismatch
);
   generate
      if (PIX_W < 2) begin : g_bad_width
         $error("pte_parity: PIX_W must be at least 2");
      end
      for (genvar k = 0; k < 3; k++) begin : g_term
         localparam int unsigned NB = (k + 1) % 3;
         logic [PIX_W-1:0] sum;
         assign sum         = pix[k] + (pix[NB] >> 1);
         assign term[k]     = sum[0];
         assign mismatch[k] = term[k] ^ msg[k];
      end
   endgenerate
endmodule

// File: rtl/pte_select.sv
module pte_select
   import pte_pkg::*;
(
   input  logic [2:0]        mismatch,
   output step_e [2:0]       step,
   output logic              defer,
   output logic              any_chg,
   output logic [1:0]        chg_idx
);
   logic [2:0] hit;

   generate
      for (genvar k = 0; k < 3; k++) begin : g_sel
         localparam int unsigned LO = (k + 2) % 3;
         localparam int unsigned HI = (k + 1) % 3;
         logic single, pair;
         assign single  = mismatch[k] && !mismatch[LO] && !mismatch[HI];
         assign pair    = mismatch[k] &&  mismatch[LO] && !mismatch[HI];
         assign step[k] = single ? STEP_MINOR : (pair ? STEP_MAJOR : STEP_NONE);
         assign hit[k]  = single || pair;
      end
   endgenerate

   assign defer   = &mismatch;
   assign any_chg = |hit;

   always_comb begin
      chg_idx = 2'd0;
      if (hit[1]) chg_idx = 2'd1;
      if (hit[2]) chg_idx = 2'd2;
   end

   always_comb begin
      assert ($onehot0(hit)) else $error("pte_select: more than one lane selected");
   end
endmodule

// File: rtl/pte_lane.sv
module pte_lane
   import pte_pkg::*;
#(
   parameter int unsigned PIX_W = 8
) (
   input  logic [PIX_W-1:0] raw,
   input  step_e            step,
   output logic [PIX_W-1:0] sat,
   output logic [PIX_W-1:0] nxt
);
   localparam logic [PIX_W-1:0] TOP = {PIX_W{1'b1}};
   localparam logic [PIX_W-1:0] ONE = {{(PIX_W-1){1'b0}}, 1'b1};

   logic [PIX_W-1:0] up, dn;

   always_comb begin
      if (raw == '0)       sat = ONE;
      else if (raw == TOP) sat = TOP - ONE;
      else                 sat = raw;
   end

   assign up = sat + ONE;
   assign dn = sat - ONE;

   always_comb begin
      unique case (step)
         STEP_MINOR: nxt = sat[0] ? dn : up;
         STEP_MAJOR: nxt = sat[0] ? up : dn;
         default:    nxt = sat;
      endcase
   end
endmodule

// File: rtl/pixel_triplet_embed.sv
module pixel_triplet_embed
   import pte_pkg::*;
#(
   parameter int unsigned PIX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [PIX_W-1:0] in_pix0,
   input  logic [PIX_W-1:0] in_pix1,
   input  logic [PIX_W-1:0] in_pix2,
   input  logic [2:0]       in_msg,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [PIX_W-1:0] out_pix0,
   output logic [PIX_W-1:0] out_pix1,
   output logic [PIX_W-1:0] out_pix2,
   output logic             out_defer,
   output logic             chg_valid,
   output logic [1:0]       chg_idx,
   output logic [PIX_W-1:0] chg_old,
   output logic [PIX_W-1:0] chg_new
);
   logic [2:0][PIX_W-1:0] raw, sat, nxt;
   logic [2:0]            term, mism;
   step_e [2:0]           step;
   logic                  defer_c, any_c;
   logic [1:0]            idx_c;

   logic                  ov_q, def_q, cv_q;
   logic [2:0][PIX_W-1:0] y_q;
   logic [1:0]            idx_q;
   logic [PIX_W-1:0]      old_q, new_q;
   logic                  take;

   assign raw = {in_pix2, in_pix1, in_pix0};

   generate
      for (genvar k = 0; k < 3; k++) begin : g_lane
         pte_lane #(.PIX_W(PIX_W)) u_lane (
            .raw (raw[k]),
            .step(step[k]),
            .sat (sat[k]),
            .nxt (nxt[k])
         );
      end
   endgenerate

   pte_parity #(.PIX_W(PIX_W)) u_par (
      .pix     (sat),
      .msg     (in_msg),
      .term    (term),
      .mismatch(mism)
   );

   pte_select u_sel (
      .mismatch(mism),
      .step    (step),
      .defer   (defer_c),
      .any_chg (any_c),
      .chg_idx (idx_c)
   );

   assign in_ready = !ov_q || out_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ov_q  <= 1'b0;
         def_q <= 1'b0;
         cv_q  <= 1'b0;
         y_q   <= '0;
         idx_q <= '0;
         old_q <= '0;
         new_q <= '0;
      end else if (take) begin
         ov_q  <= 1'b1;
         def_q <= defer_c;
         cv_q  <= any_c;
         y_q   <= nxt;
         idx_q <= idx_c;
         old_q <= sat[idx_c];
         new_q <= nxt[idx_c];
      end else if (out_ready) begin
         ov_q  <= 1'b0;
      end
   end

   assign out_valid = ov_q;
   assign out_pix0  = y_q[0];
   assign out_pix1  = y_q[1];
   assign out_pix2  = y_q[2];
   assign out_defer = def_q;
   assign chg_valid = ov_q && cv_q;
   assign chg_idx   = idx_q;
   assign chg_old   = old_q;
   assign chg_new   = new_q;

   // Output-side parity, computed by a separate instance for checking.
   logic [2:0] out_term, out_mism_unused;
   pte_parity #(.PIX_W(PIX_W)) u_chk_par (
      .pix     (y_q),
      .msg     (3'b000),
      .term    (out_term),
      .mismatch(out_mism_unused)
   );

   // R1
   parity_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (out_defer || (out_term == $past(in_msg))));

   // R8
   accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> out_valid);

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_pix0) && $stable(out_pix1)
                                     && $stable(out_pix2) && $stable(out_defer) && $stable(chg_valid)));

   // R6
   defer_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_defer) |-> !chg_valid);

   // R7
   unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chg_valid |-> ((chg_new == chg_old + 1'b1) || (chg_old == chg_new + 1'b1)));
endmodule

// File: tb/tb_pixel_triplet_embed.sv
module tb_pixel_triplet_embed;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_pix0 = '0, in_pix1 = '0, in_pix2 = '0;
   logic [2:0] in_msg = '0;
   logic       out_valid;
   logic       out_ready = 1'b1;
   logic [7:0] out_pix0, out_pix1, out_pix2;
   logic       out_defer, chg_valid;
   logic [1:0] chg_idx;
   logic [7:0] chg_old, chg_new;

   int n_checks = 0;
   int n_fail   = 0;
   bit stall_en = 1'b0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   pixel_triplet_embed dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_pix0(in_pix0), .in_pix1(in_pix1), .in_pix2(in_pix2), .in_msg(in_msg),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_pix0(out_pix0), .out_pix1(out_pix1), .out_pix2(out_pix2),
      .out_defer(out_defer), .chg_valid(chg_valid), .chg_idx(chg_idx),
      .chg_old(chg_old), .chg_new(chg_new)
   );

   typedef struct {
      logic [7:0] y0, y1, y2;
      logic       dfr, cv;
      logic [1:0] idx;
      logic [7:0] oldv, newv;
      logic [2:0] msg;
      string      tag;
   } exp_t;

   exp_t sb[$];

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic logic fpar(input logic [7:0] a, input logic [7:0] b);
      logic [8:0] s;
      s = {1'b0, a} + {2'b00, b[7:1]};
      return s[0];
   endfunction

   function automatic logic [7:0] satv(input logic [7:0] v);
      if (v == 8'd0)   return 8'd1;
      if (v == 8'd255) return 8'd254;
      return v;
   endfunction

   function automatic logic [7:0] minor_step(input logic [7:0] v);
      return (v % 2 == 0) ? v + 8'd1 : v - 8'd1;
   endfunction

   function automatic logic [7:0] major_step(input logic [7:0] v);
      return (v % 2 == 0) ? v - 8'd1 : v + 8'd1;
   endfunction

   function automatic exp_t model(input logic [7:0] a, b, c, input logic [2:0] m);
      exp_t e;
      logic [7:0] s [3];
      logic [2:0] f, r;
      int k;
      s[0] = satv(a); s[1] = satv(b); s[2] = satv(c);
      f = {fpar(s[2], s[0]), fpar(s[1], s[2]), fpar(s[0], s[1])};
      r = m ^ f;
      e.dfr = 1'b0; e.cv = 1'b0; e.idx = 2'd0; e.msg = m;
      k = -1;
      case (r)
         3'b000: e.tag = "R3";
         3'b111: begin e.tag = "R6"; e.dfr = 1'b1; end
         3'b001, 3'b010, 3'b100: begin
            e.tag = "R4";
            k = (r == 3'b001) ? 0 : (r == 3'b010) ? 1 : 2;
         end
         default: begin
            e.tag = "R5";
            k = (r == 3'b011) ? 1 : (r == 3'b110) ? 2 : 0;
         end
      endcase
      e.oldv = 8'd0; e.newv = 8'd0;
      if (k >= 0) begin
         e.cv   = 1'b1;
         e.idx  = 2'(k);
         e.oldv = s[k];
         e.newv = (e.tag == "R4") ? minor_step(s[k]) : major_step(s[k]);
         s[k]   = e.newv;
      end
      e.y0 = s[0]; e.y1 = s[1]; e.y2 = s[2];
      if (a == 8'd0 || a == 8'd255 || b == 8'd0 || b == 8'd255 || c == 8'd0 || c == 8'd255)
         e.tag = {e.tag, "/R2"};
      return e;
   endfunction

   task automatic send(input logic [7:0] a, b, c, input logic [2:0] m);
      @(negedge clk);
      in_valid = 1'b1;
      in_pix0 = a; in_pix1 = b; in_pix2 = c; in_msg = m;
      sb.push_back(model(a, b, c, m));
      #2;
      while (!in_ready) begin
         @(negedge clk);
         #2;
      end
      @(posedge clk);
      #2;
      // R8: result present right after the acceptance edge
      check(out_valid === 1'b1, "R8", "out_valid after accept", int'(out_valid), 1);
   endtask

   // Send a group whose mismatch vector equals r (computed from the requirement).
   task automatic send_r(input logic [7:0] a, b, c, input logic [2:0] r);
      logic [7:0] s0, s1, s2;
      logic [2:0] f;
      s0 = satv(a); s1 = satv(b); s2 = satv(c);
      f = {fpar(s2, s0), fpar(s1, s2), fpar(s0, s1)};
      send(a, b, c, f ^ r);
   endtask

   // Monitor / scoreboard
   initial begin : monitor
      logic       held = 1'b0;
      logic [7:0] h0, h1, h2;
      logic       hd, hc;
      exp_t       e;
      forever begin
         @(negedge clk);
         out_ready = stall_en ? (($urandom % 4) != 0) : 1'b1;
         #1;
         if (rst_n) begin
            if (held) begin
               // R8: outputs held during stall
               check(out_valid === 1'b1 && out_pix0 === h0 && out_pix1 === h1 && out_pix2 === h2
                     && out_defer === hd && chg_valid === hc,
                     "R8", "hold during stall", int'(out_pix0), int'(h0));
            end
            held = 1'b0;
            if (out_valid && out_ready) begin
               if (sb.size() == 0) begin
                  check(1'b0, "R8", "unexpected output", 1, 0);
               end else begin
                  e = sb.pop_front();
                  check(out_pix0 === e.y0, e.tag, "out_pix0", int'(out_pix0), int'(e.y0));
                  check(out_pix1 === e.y1, e.tag, "out_pix1", int'(out_pix1), int'(e.y1));
                  check(out_pix2 === e.y2, e.tag, "out_pix2", int'(out_pix2), int'(e.y2));
                  check(out_defer === e.dfr, e.tag, "out_defer", int'(out_defer), int'(e.dfr));
                  check(chg_valid === e.cv, "R7", "chg_valid", int'(chg_valid), int'(e.cv));
                  if (e.cv) begin
                     check(chg_idx === e.idx, "R7", "chg_idx", int'(chg_idx), int'(e.idx));
                     check(chg_old === e.oldv, "R7", "chg_old", int'(chg_old), int'(e.oldv));
                     check(chg_new === e.newv, "R7", "chg_new", int'(chg_new), int'(e.newv));
                  end
                  if (!e.dfr) begin
                     // R1: parity terms of output equal message
                     check({fpar(out_pix2, out_pix0), fpar(out_pix1, out_pix2), fpar(out_pix0, out_pix1)} === e.msg,
                           "R1", "output parity",
                           int'({fpar(out_pix2, out_pix0), fpar(out_pix1, out_pix2), fpar(out_pix0, out_pix1)}),
                           int'(e.msg));
                  end
               end
            end else if (out_valid && !out_ready) begin
               held = 1'b1;
               h0 = out_pix0; h1 = out_pix1; h2 = out_pix2; hd = out_defer; hc = chg_valid;
            end
         end
      end
   end

   initial begin : watchdog
      #(20 * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1'b1;
      @(negedge clk);
      #3;
      // R9
      check(out_valid === 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
      check(in_ready === 1'b1, "R9", "in_ready after reset", int'(in_ready), 1);

      // R3: no mismatch
      send_r(8'd100, 8'd37, 8'd200, 3'b000);
      // R4: one bit, even and odd pixels
      send_r(8'd100, 8'd37, 8'd200, 3'b001);
      send_r(8'd101, 8'd36, 8'd200, 3'b010);
      send_r(8'd100, 8'd37, 8'd201, 3'b100);
      send_r(8'd55, 8'd36, 8'd200, 3'b001);
      // R5: two bits, each pattern, even and odd
      send_r(8'd100, 8'd37, 8'd200, 3'b011);
      send_r(8'd100, 8'd38, 8'd200, 3'b011);
      send_r(8'd100, 8'd37, 8'd200, 3'b110);
      send_r(8'd100, 8'd37, 8'd203, 3'b110);
      send_r(8'd100, 8'd37, 8'd200, 3'b101);
      send_r(8'd99, 8'd37, 8'd200, 3'b101);
      // R6: deferred
      send_r(8'd100, 8'd37, 8'd200, 3'b111);
      // R2: saturation at both ends with several mismatch vectors
      for (int r = 0; r < 8; r++) begin
         send_r(8'd0, 8'd255, 8'd0, 3'(r));
         send_r(8'd255, 8'd0, 8'd255, 3'(r));
      end

      // Random groups with output back-pressure
      stall_en = 1'b1;
      for (int i = 0; i < 400; i++) begin
         send(8'($urandom), 8'($urandom), 8'($urandom), 3'($urandom));
      end
      stall_en = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      for (int w = 0; w < 50 && sb.size() != 0; w++) @(negedge clk);
      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R8", "scoreboard drained", sb.size(), 0);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule